// File: doc/BRIEF.md
# Bidirectional Stall-Wave Controller for Error-Correcting Pipelines

This block is the clock-enable control plane for a pipeline whose registers each pair a main capture element with a late-sampling shadow element. When one stage flags a late-arriving result, the block turns that local event into a one-cycle correction. A forward stall wave travels toward the consumers and a backward hold wave travels toward the producers, each moving one stage per clock. Producers first freeze only their main element, so the shadow element still takes in the token that is in flight. The next cycle they freeze both elements. No token is dropped and none is taken twice.

The network is a set of identical per-stage controllers joined by a parameter mask. Each stage ORs the requests sent by its neighbours. Waves of opposite kind that meet at a stage, or that cross between two stages, are absorbed, so propagation always dies out, including around loops. For every stage the block drives a main enable, a shadow enable and a restore strobe that copies shadow into main.

Top module: `stall_net`

## Requirements
- R1: After reset every main and shadow enable is 1 and every restore strobe is 0.
- R2: In a cycle where a stage's error input is high, both of its enables are 0. In the next cycle it sends a forward stall to each consumer and a backward hold to each producer.
- R3: A stage that takes in an effective forward stall has both enables 0 for that one cycle. In the next cycle it sends a hold to its producers and a stall to its consumers.
- R4: A stage that takes in an effective hold has main enable 0 and shadow enable 1 in that cycle. In the next cycle it has both enables 0 and sends stall and hold onward. The shadow enable is never 0 while the main enable is 1.
- R5: Each request reaches its neighbour in the clock cycle after the decision that produced it. An error at the last stage of a five-stage chain freezes stage 3, 2, 1 and 0 fully at 2, 4, 6 and 8 cycles after the error.
- R6: A stage that takes in a stall and a hold in the same cycle has both enables 0 for that cycle and sends nothing.
- R7: A request is dropped if the opposite kind was sent by the receiving stage in the current cycle or in either of the two cycles before. This covers the echo of its own wave and waves that cross it.
- R8: Restore is 1 for exactly one cycle. It follows an error cycle, or the full-freeze cycle that follows a main-only hold. A stall-only or meet freeze gives no restore.
- R9: A stage in its full-freeze cycle after a hold ignores every incoming request.
- R10: Topology is set by PRED_MASK: bit i*NS+j set means stage j feeds stage i. The block supports fan-in and fan-out.
- R11: After one error the network goes back to all enables 1 and no restore within 2*NS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | NS | Per-stage late-data flag |
| main_en_o | output | NS | Per-stage main element enable |
| shadow_en_o | output | NS | Per-stage shadow element enable |
| restore_o | output | NS | Per-stage copy shadow into main |

## Verification
The assertions assume that err_i is driven only after reset has been released and is stable across each sampling edge. They also assume that a stage never raises its error flag in a cycle where it is already frozen. The stimulus pulses error flags for a single cycle, one scenario at a time. It waits until the previous wave has died out before the next pulse, so every expected enable pattern can be worked out by hand from the hop and drop rules. The scenarios cover a mid-chain error, a tail error that walks the full chain, a simultaneous pair whose waves meet, and a diamond graph with fan-out and fan-in.

// File: rtl/stall_pkg.sv
package stall_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } stage_st_e;
endpackage

// File: rtl/stall_stage.sv
module stall_stage
    import stall_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    input  logic cg_in_i,
    input  logic mcg_in_i,
    output logic main_en_o,
    output logic shadow_en_o,
    output logic restore_o,
    output logic cg_snd_o,
    output logic mcg_snd_o
);
    // Window of past sends that absorbs echoes and crossing waves (R7)
    localparam int ECHO_WIN = 2;

    stage_st_e st_q, st_d;
    logic cg_snd_d, mcg_snd_d, rs_d;
    logic [ECHO_WIN-1:0] cg_hist_q, mcg_hist_q;
    logic cg_recent, mcg_recent, cg_hit, mcg_hit;

    assign cg_recent  = cg_snd_o  | (|cg_hist_q);
    assign mcg_recent = mcg_snd_o | (|mcg_hist_q);
    assign cg_hit     = cg_in_i  & ~mcg_recent;
    assign mcg_hit    = mcg_in_i & ~cg_recent;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_RUN;
            cg_snd_o   <= 1'b0;
            mcg_snd_o  <= 1'b0;
            restore_o  <= 1'b0;
            cg_hist_q  <= '0;
            mcg_hist_q <= '0;
        end else begin
            st_q       <= st_d;
            cg_snd_o   <= cg_snd_d;
            mcg_snd_o  <= mcg_snd_d;
            restore_o  <= rs_d;
            cg_hist_q  <= {cg_hist_q[ECHO_WIN-2:0], cg_snd_o};
            mcg_hist_q <= {mcg_hist_q[ECHO_WIN-2:0], mcg_snd_o};
        end
    end

    // Decision and outputs
    always_comb begin
        st_d        = ST_RUN;
        main_en_o   = 1'b1;
        shadow_en_o = 1'b1;
        cg_snd_d    = 1'b0;
        mcg_snd_d   = 1'b0;
        rs_d        = 1'b0;
        unique case (st_q)
            ST_PEND: begin
                main_en_o   = 1'b0;
                shadow_en_o = 1'b0;
                cg_snd_d    = 1'b1;
                mcg_snd_d   = 1'b1;
                rs_d        = 1'b1;
            end
            ST_RUN: begin
                if (err_i) begin
                    main_en_o   = 1'b0;
                    shadow_en_o = 1'b0;
                    cg_snd_d    = 1'b1;
                    mcg_snd_d   = 1'b1;
                    rs_d        = 1'b1;
                end else if (cg_hit && mcg_hit) begin
                    main_en_o   = 1'b0;
                    shadow_en_o = 1'b0;
                end else if (cg_hit) begin
                    main_en_o   = 1'b0;
                    shadow_en_o = 1'b0;
                    cg_snd_d    = 1'b1;
                    mcg_snd_d   = 1'b1;
                end else if (mcg_hit) begin
                    main_en_o = 1'b0;
                    st_d      = ST_PEND;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/stall_link.sv
module stall_link #(
    parameter int NS = 5,
    parameter int IDX = 0,
    parameter logic [NS*NS-1:0] PRED_MASK = '0
) (
    input  logic [NS-1:0] cg_snd_i,
    input  logic [NS-1:0] mcg_snd_i,
    output logic          cg_in_o,
    output logic          mcg_in_o
);
    logic [NS-1:0] pred_row, succ_row;

    for (genvar k = 0; k < NS; k++) begin : g_row
        assign pred_row[k] = PRED_MASK[IDX*NS + k];
        assign succ_row[k] = PRED_MASK[k*NS + IDX];
    end

    assign cg_in_o  = |(cg_snd_i & pred_row);
    assign mcg_in_o = |(mcg_snd_i & succ_row);
endmodule

// File: rtl/stall_net.sv
module stall_net #(
    parameter int NS = 5,
    parameter logic [NS*NS-1:0] PRED_MASK = 25'h0820820
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] err_i,
    output logic [NS-1:0] main_en_o,
    output logic [NS-1:0] shadow_en_o,
    output logic [NS-1:0] restore_o
);
    logic [NS-1:0] cg_snd, mcg_snd, cg_in, mcg_in;

    for (genvar i = 0; i < NS; i++) begin : g_stage
        stall_link #(.NS(NS), .IDX(i), .PRED_MASK(PRED_MASK)) u_link (
            .cg_snd_i (cg_snd),
            .mcg_snd_i(mcg_snd),
            .cg_in_o  (cg_in[i]),
            .mcg_in_o (mcg_in[i])
        );
        stall_stage u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .err_i      (err_i[i]),
            .cg_in_i    (cg_in[i]),
            .mcg_in_i   (mcg_in[i]),
            .main_en_o  (main_en_o[i]),
            .shadow_en_o(shadow_en_o[i]),
            .restore_o  (restore_o[i]),
            .cg_snd_o   (cg_snd[i]),
            .mcg_snd_o  (mcg_snd[i])
        );
    end
endmodule

// File: rtl/stall_net_chk.sv
module stall_net_chk #(
    parameter int NS = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NS-1:0] err_i,
    input logic [NS-1:0] main_en_o,
    input logic [NS-1:0] shadow_en_o,
    input logic [NS-1:0] restore_o,
    input logic [NS-1:0] cg_snd,
    input logic [NS-1:0] mcg_snd
);
    for (genvar g = 0; g < NS; g++) begin : g_chk
        a_r2_err_freezes: assert property (@(posedge clk) disable iff (!rst_n)
            err_i[g] |-> (!main_en_o[g] && !shadow_en_o[g]));
        a_r4_shadow_implies_main: assert property (@(posedge clk) disable iff (!rst_n)
            !shadow_en_o[g] |-> !main_en_o[g]);
        a_r4_hold_then_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            (!main_en_o[g] && shadow_en_o[g]) |=> (!main_en_o[g] && !shadow_en_o[g]));
        a_r8_restore_after_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            restore_o[g] |-> $past(!main_en_o[g] && !shadow_en_o[g]));
        a_r8_restore_single: assert property (@(posedge clk) disable iff (!rst_n)
            restore_o[g] |=> !restore_o[g]);
        a_r5_hold_send_after_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            mcg_snd[g] |-> $past(!main_en_o[g] && !shadow_en_o[g]));
        a_r5_stall_send_after_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            cg_snd[g] |-> $past(!main_en_o[g] && !shadow_en_o[g]));
    end
endmodule

bind stall_net stall_net_chk #(.NS(NS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_i      (err_i),
    .main_en_o  (main_en_o),
    .shadow_en_o(shadow_en_o),
    .restore_o  (restore_o),
    .cg_snd     (cg_snd),
    .mcg_snd    (mcg_snd)
);

// File: tb/test_stall_net.sv
`timescale 1ns/1ps
module test_stall_net;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] lin_err = '0;
    logic [3:0] fan_err = '0;
    logic [4:0] lin_me, lin_se, lin_rs;
    logic [3:0] fan_me, fan_se, fan_rs;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stall_net i_stall_net (
        .clk(clk), .rst_n(rst_n), .err_i(lin_err),
        .main_en_o(lin_me), .shadow_en_o(lin_se), .restore_o(lin_rs)
    );

    // R10 diamond: 0->1, 0->2, 1->3, 2->3 (bit i*4+j: j feeds i)
    stall_net #(.NS(4), .PRED_MASK(16'h6110)) i_stall_net_fan (
        .clk(clk), .rst_n(rst_n), .err_i(fan_err),
        .main_en_o(fan_me), .shadow_en_o(fan_se), .restore_o(fan_rs)
    );

    typedef struct {
        logic [4:0] lme, lse, lrs;
        logic [3:0] fme, fse, frs;
        string tag;
    } exp_t;

    exp_t q[$];

    function automatic exp_t idle(string tag);
        exp_t e;
        e.lme = 5'h1f; e.lse = 5'h1f; e.lrs = '0;
        e.fme = 4'hf;  e.fse = 4'hf;  e.frs = '0;
        e.tag = tag;
        return e;
    endfunction

    task automatic chk(string tag, string what, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Monitor: pop one expected entry per cycle, compare at the falling edge
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "lin main_en", lin_me, e.lme);
            chk(e.tag, "lin shadow_en", lin_se, e.lse);
            chk(e.tag, "lin restore", lin_rs, e.lrs);
            chk(e.tag, "fan main_en", {1'b0, fan_me}, {1'b0, e.fme});
            chk(e.tag, "fan shadow_en", {1'b0, fan_se}, {1'b0, e.fse});
            chk(e.tag, "fan restore", {1'b0, fan_rs}, {1'b0, e.frs});
        end
    end

    // Driver: pulse errors for one cycle and queue the expected pattern
    task automatic fire(input logic [4:0] le, input logic [3:0] fe, input exp_t s[$]);
        @(posedge clk); #2;
        lin_err = le;
        fan_err = fe;
        foreach (s[k]) q.push_back(s[k]);
        @(posedge clk); #2;
        lin_err = '0;
        fan_err = '0;
        repeat (s.size()) @(posedge clk);
    endtask

    task automatic scn_mid_error();
        exp_t s[$];
        for (int k = 0; k < 7; k++) s.push_back(idle("R2 R3 R4 R7 R8"));
        s[0].lme[2] = 0; s[0].lse[2] = 0;
        s[1].lme[1] = 0; s[1].lrs[2] = 1; s[1].lme[3] = 0; s[1].lse[3] = 0;
        s[2].lme[1] = 0; s[2].lse[1] = 0; s[2].lme[4] = 0; s[2].lse[4] = 0;
        s[3].lme[0] = 0; s[3].lrs[1] = 1;
        s[4].lme[0] = 0; s[4].lse[0] = 0;
        s[5].lrs[0] = 1;
        fire(5'b00100, 4'b0000, s);
    endtask

    task automatic scn_meet();
        exp_t s[$];
        for (int k = 0; k < 5; k++) s.push_back(idle("R6 R7 R8"));
        s[0].lme[1] = 0; s[0].lse[1] = 0; s[0].lme[3] = 0; s[0].lse[3] = 0;
        s[1].lme[0] = 0; s[1].lrs[1] = 1; s[1].lme[2] = 0; s[1].lse[2] = 0;
        s[1].lrs[3] = 1; s[1].lme[4] = 0; s[1].lse[4] = 0;
        s[2].lme[0] = 0; s[2].lse[0] = 0;
        s[3].lrs[0] = 1;
        fire(5'b01010, 4'b0000, s);
    endtask

    task automatic scn_tail_walk();
        exp_t s[$];
        for (int k = 0; k < 11; k++) s.push_back(idle("R5 R11"));
        s[0].lme[4] = 0; s[0].lse[4] = 0;
        s[1].lrs[4] = 1;
        for (int j = 3; j >= 0; j--) begin
            int b;
            b = 1 + 2 * (3 - j);
            s[b].lme[j] = 0;
            s[b+1].lme[j] = 0; s[b+1].lse[j] = 0;
            s[b+2].lrs[j] = 1;
        end
        fire(5'b10000, 4'b0000, s);
    endtask

    task automatic scn_diamond();
        exp_t s[$];
        for (int k = 0; k < 6; k++) s.push_back(idle("R9 R10"));
        s[0].fme[1] = 0; s[0].fse[1] = 0;
        s[1].fme[0] = 0; s[1].frs[1] = 1; s[1].fme[3] = 0; s[1].fse[3] = 0;
        s[2].fme[0] = 0; s[2].fse[0] = 0; s[2].fme[2] = 0;
        s[3].frs[0] = 1; s[3].fme[2] = 0; s[3].fse[2] = 0;
        s[4].frs[2] = 1;
        fire(5'b00000, 4'b0010, s);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        for (int k = 0; k < 3; k++) q.push_back(idle("R1"));
        repeat (4) @(posedge clk);
        scn_mid_error();
        repeat (3) @(posedge clk);
        scn_meet();
        repeat (3) @(posedge clk);
        scn_tail_walk();
        repeat (3) @(posedge clk);
        scn_diamond();
        @(posedge clk); #2;
        for (int k = 0; k < 4; k++) q.push_back(idle("R11"));
        repeat (6) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule